// File: doc/BRIEF.md
# Dual-Channel Event Performance Counter

This block measures processor behaviour with two measurement channels that run side by side. Each channel watches one selected line of a per-cycle event strobe vector, or simply counts elapsed cycles. A selected strobe that is high in a cycle stands for one occurrence, even when the event behind it happened twice in that cycle. Each count is held in a wide accumulator, 48 bits by default. If the accumulator would pass its maximum, the count stops and a sticky flag marks it as invalid. The count does not wrap.

A channel can count over the whole run, which is every cycle that `run` is high. It can also count only inside a window. The window opens when the fetch-stage PC equals a programmed start address and closes when it equals a programmed end address. One start/end pair is shared by both channels. Each channel also chooses how much a counted cycle adds. In CPU-clock mode it adds one. In ratio mode it adds a weight of 3, 4, 6, 8, 12 or 24, picked from the CPU-to-bus clock ratio code. In ratio mode, elapsed time is the count times one bus-clock period divided by 24.

Software configures the block through a small write port and reads it through a read port. A count wider than the read data path is read as a low part and a high part. The high part is captured when the low part is read, so the two reads describe the same instant.

Top module: `perf_counter_top`

## Requirements
- R1: After reset, both counts are zero, both overflow flags are clear, the PC window is closed, the ratio code is 0 and both channel configurations are zero.
- R2: A channel without windowing counts in every cycle where `run` is high and its selected strobe `evt_strobe[sel]` is high. In elapsed mode (configuration bit 8) it counts every cycle where `run` is high. When `run` is low, nothing is counted. A counted cycle is visible in the count one clock later.
- R3: The two channels count at the same time and independently, each using its own select field (configuration bits [3:0] at write addresses 0 and 1). A strobe that is high adds exactly one weight per cycle.
- R4: If configuration bit 9 is 0, a counted cycle adds 1. If it is 1, a counted cycle adds a weight set by the ratio code (write address 4, bits [2:0]): code 0 gives 3, 1 gives 4, 2 gives 6, 3 gives 8, 4 gives 12, and 5, 6 or 7 give 24.
- R5: A channel with configuration bit 10 set counts only while the PC window is open. A cycle with `pc_valid` high and `fetch_pc` equal to the start address opens the window from the next cycle. A cycle that matches the end address, and not the start address, closes it after that cycle; the end cycle itself is counted. If the start and end addresses match in the same cycle, the window opens. A cycle with `run` low closes the window.
- R6: The start address (write address 2) and the end address (write address 3) are one pair that serves both channels. Rewriting an address replaces the old value for both channels at once.
- R7: If adding to a count would exceed 2^CNT_W-1, the count is held at all ones and the overflow flag is set. After that, the count stays unchanged and the flag stays set until the channel is cleared.
- R8: Pulsing `clear[i]`, or writing the configuration of channel i, sets that channel's count to zero and clears its overflow flag at that clock edge. This takes precedence over any counting in the same cycle.
- R9: Read address 2*i returns the low LO_W bits of channel i's count, zero-extended. Read address 2*i+1 returns, in its low bits, the upper CNT_W-LO_W bits captured at the clock edge that ends a cycle in which `rd_en` was high with address 2*i. Bit 31 of that word is the live overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High while the measured program runs |
| clear | input | NUM_CH (2) | Per-channel count clear pulse |
| evt_strobe | input | EVT_N | One-cycle event pulses, one bit per event |
| pc_valid | input | 1 | Fetch-stage PC is valid this cycle |
| fetch_pc | input | PC_W | Fetch-stage program counter |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Write address: 0/1 channel configuration, 2 start address, 3 end address, 4 ratio code |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe; a low-part read captures the high part |
| rd_addr | input | 2 | Read address: bit 1 selects the channel, bit 0 selects the high part |
| rd_data | output | DATA_W | Read data (combinational) |

## Verification
The hardest condition to reach from the ports is overflow, because a 48-bit count cannot fill within a run of practical length. The bench therefore builds the block with a 14-bit count and an 8-bit low part. It then drives an elapsed-cycle channel at the largest ratio weight, so the limit is crossed in a few hundred cycles. The start-over-end priority can only be reached by programming the same address as both start and end, and the bench does exactly that. To show that a high-part read is coherent, the bench reads the low part exactly when it is about to roll over and checks that the high part read next still belongs to the earlier value.

// File: rtl/perf_pkg.sv
// Package: shared constants, configuration type and weight lookup for the
// dual-channel performance counter. Assumes at most 256 event lines.
package perf_pkg;

    localparam int NUM_CH = 2;

    // Write-port addresses
    localparam logic [2:0] WA_CFG0  = 3'd0;
    localparam logic [2:0] WA_CFG1  = 3'd1;
    localparam logic [2:0] WA_START = 3'd2;
    localparam logic [2:0] WA_END   = 3'd3;
    localparam logic [2:0] WA_RATIO = 3'd4;

    // Per-channel configuration, packed in write-data bit order [10:0]
    typedef struct packed {
        logic       range_en;   // bit 10: count only inside PC window
        logic       ratio_clk;  // bit 9 : add ratio weight instead of one
        logic       elapsed;    // bit 8 : count every running cycle
        logic [7:0] sel;        // bits 7:0: event line select
    } ch_cfg_t;

    // Weight added per counted cycle in ratio mode
    function automatic logic [4:0] ratio_weight(input logic [2:0] code);
        case (code)
            3'd0:    ratio_weight = 5'd3;
            3'd1:    ratio_weight = 5'd4;
            3'd2:    ratio_weight = 5'd6;
            3'd3:    ratio_weight = 5'd8;
            3'd4:    ratio_weight = 5'd12;
            default: ratio_weight = 5'd24;
        endcase
    endfunction

endpackage

// File: rtl/perf_range_gate.sv
// Module: PC window gate shared by both channels.
// Opens the cycle after a start-address match and closes after an
// end-address match; start wins when both match. Assumes fetch_pc is
// sampled once per cycle and that run low ends any open window.
module perf_range_gate #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            pc_valid,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic [PC_W-1:0] start_pc,
    input  logic [PC_W-1:0] end_pc,
    output logic            gate_open
);

    logic start_hit;
    logic end_hit;
    logic gate_q;

    // Decode address matches for this cycle
    always_comb begin
        start_hit = pc_valid && (fetch_pc == start_pc);
        end_hit   = pc_valid && (fetch_pc == end_pc);
    end

    // Window state: start has priority over end
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            gate_q <= 1'b0;
        end else if (start_hit) begin
            gate_q <= 1'b1;
        end else if (end_hit) begin
            gate_q <= 1'b0;
        end
    end

    assign gate_open = gate_q;

    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pc_valid && fetch_pc == start_pc) |=> gate_open); // R5

    AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pc_valid && fetch_pc == end_pc && fetch_pc != start_pc) |=> !gate_open); // R5

    AST_IDLE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !gate_open); // R5

endmodule

// File: rtl/perf_channel.sv
// Module: one measurement channel. Qualifies the selected strobe (or every
// cycle) by run and the PC window, adds one or the ratio weight, and on
// overflow saturates and raises a sticky flag. Assumes EVT_N is a power of
// two no larger than 256 and CNT_W >= 5.
module perf_channel
    import perf_pkg::*;
#(
    parameter int CNT_W = 48,
    parameter int EVT_N = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             gate_open,
    input  logic             clr,
    input  ch_cfg_t          cfg,
    input  logic [2:0]       ratio_code,
    input  logic [EVT_N-1:0] evt,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    localparam int SEL_W = $clog2(EVT_N);

    logic             hit;
    logic             cnt_en;
    logic [4:0]       inc;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    // Decide whether this cycle counts and by how much
    always_comb begin
        hit    = cfg.elapsed || evt[cfg.sel[SEL_W-1:0]];
        cnt_en = run && (!cfg.range_en || gate_open) && hit;
        inc    = cfg.ratio_clk ? ratio_weight(ratio_code) : 5'd1;
        sum    = {1'b0, cnt_q} + (CNT_W+1)'(inc);
    end

    // Accumulate; clear wins, overflow freezes the count at all ones
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (!ovf_q && cnt_en) begin
            if (sum[CNT_W]) begin
                cnt_q <= '1;
                ovf_q <= 1'b1;
            end else begin
                cnt_q <= sum[CNT_W-1:0];
            end
        end
    end

    assign cnt = cnt_q;
    assign ovf = ovf_q;

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && !ovf_q)); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr) |=> ovf_q); // R7

    AST_OVF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr) |=> $stable(cnt_q)); // R7

    AST_OVF_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> (&cnt_q)); // R7

    AST_NO_RUN_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt_q)); // R2

    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && !ovf_q) |=> (ovf_q || (cnt_q - $past(cnt_q)) <= CNT_W'(24))); // R4

endmodule

// File: rtl/perf_counter_top.sv
// Module: dual-channel performance counter top. Holds configuration, the
// shared PC pair and ratio code; instantiates the PC gate and one channel
// per measurement slot; provides a split low/high read with a high-part
// capture on low reads. Assumes LO_W <= DATA_W, PC_W <= DATA_W and
// CNT_W - LO_W < DATA_W.
module perf_counter_top
    import perf_pkg::*;
#(
    parameter int CNT_W  = 48,
    parameter int LO_W   = 32,
    parameter int EVT_N  = 16,
    parameter int PC_W   = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [NUM_CH-1:0] clear,
    input  logic [EVT_N-1:0]  evt_strobe,
    input  logic              pc_valid,
    input  logic [PC_W-1:0]   fetch_pc,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int HI_W = CNT_W - LO_W;

    logic [PC_W-1:0]  start_q;
    logic [PC_W-1:0]  end_q;
    logic [2:0]       ratio_q;
    logic             gate_open;
    logic [CNT_W-1:0] cnt_w  [NUM_CH];
    logic [HI_W-1:0]  hi_lat [NUM_CH];
    logic [NUM_CH-1:0] ovf_w;

    // Shared window addresses and ratio code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
            ratio_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                WA_START: start_q <= wr_data[PC_W-1:0];
                WA_END:   end_q   <= wr_data[PC_W-1:0];
                WA_RATIO: ratio_q <= wr_data[2:0];
                default:  ;
            endcase
        end
    end

    perf_range_gate #(.PC_W(PC_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .pc_valid  (pc_valid),
        .fetch_pc  (fetch_pc),
        .start_pc  (start_q),
        .end_pc    (end_q),
        .gate_open (gate_open)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [2:0] MY_WA  = 3'(g);
        localparam logic       MY_BIT = 1'(g);

        ch_cfg_t cfg_q;
        logic    cfg_wr;
        logic    ch_clr;

        // Configuration write strobe and derived clear for this channel
        always_comb begin
            cfg_wr = wr_en && (wr_addr == MY_WA);
            ch_clr = clear[g] || cfg_wr;
        end

        // Channel configuration register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q <= '0;
            end else if (cfg_wr) begin
                cfg_q <= wr_data[10:0];
            end
        end

        // Capture the high part when the low part is read
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_lat[g] <= '0;
            end else if (rd_en && !rd_addr[0] && rd_addr[1] == MY_BIT) begin
                hi_lat[g] <= cnt_w[g][CNT_W-1:LO_W];
            end
        end

        perf_channel #(.CNT_W(CNT_W), .EVT_N(EVT_N)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (run),
            .gate_open  (gate_open),
            .clr        (ch_clr),
            .cfg        (cfg_q),
            .ratio_code (ratio_q),
            .evt        (evt_strobe),
            .cnt        (cnt_w[g]),
            .ovf        (ovf_w[g])
        );

        AST_HI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !rd_addr[0] && rd_addr[1] == MY_BIT)
            |=> hi_lat[g] == $past(cnt_w[g][CNT_W-1:LO_W])); // R9

        AST_CFG_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == MY_WA) |=> (cnt_w[g] == '0 && !ovf_w[g])); // R8
    end

    // Read multiplexer: low part live, high part from capture, flag on top
    always_comb begin
        logic [DATA_W-1:0] hi_word;
        hi_word = DATA_W'(hi_lat[rd_addr[1]]);
        hi_word[DATA_W-1] = ovf_w[rd_addr[1]];
        if (rd_addr[0]) begin
            rd_data = hi_word;
        end else begin
            rd_data = DATA_W'(cnt_w[rd_addr[1]][LO_W-1:0]);
        end
    end

endmodule

// File: tb/tb_perf_counter_top.sv
`timescale 1ns/1ps
module tb_perf_counter_top;

    localparam int  CNT_W = 14;
    localparam int  LO_W  = 8;
    localparam int  EVT_N = 16;
    localparam longint MAXC = (64'd1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run;
    logic [1:0]  clear;
    logic [15:0] evt_strobe;
    logic        pc_valid;
    logic [31:0] fetch_pc;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic        rd_en;
    logic [1:0]  rd_addr;
    logic [31:0] rd_data;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    bit  rnd_evt = 0;
    logic [15:0] lfsr = 16'hACE1;

    perf_counter_top #(.CNT_W(CNT_W), .LO_W(LO_W), .EVT_N(EVT_N),
                       .PC_W(32), .DATA_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .run(run), .clear(clear),
        .evt_strobe(evt_strobe), .pc_valid(pc_valid), .fetch_pc(fetch_pc),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;   // 50 MHz

    // ---------------- behavioural reference model ----------------
    longint m_cnt [2];
    bit     m_ovf [2];
    longint m_hi  [2];
    int     m_cfg [2];
    int     m_ratio;
    longint m_start, m_end;
    bit     m_gate;

    longint t_cnt [2];
    bit     t_ovf [2];
    longint t_hi  [2];
    bit     t_en, t_clr;
    int     t_sel;
    longint t_inc, t_sum;

    function automatic int wgt(int code);
        case (code)
            0: return 3;
            1: return 4;
            2: return 6;
            3: return 8;
            4: return 12;
            default: return 24;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 0; m_ovf[i] = 0; m_hi[i] = 0; m_cfg[i] = 0;
            end
            m_ratio = 0; m_start = 0; m_end = 0; m_gate = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                t_hi[i] = (rd_en && rd_addr == 2'(2*i)) ? (m_cnt[i] >> LO_W) : m_hi[i];
                t_clr = clear[i] || (wr_en && wr_addr == 3'(i));
                t_sel = m_cfg[i] & 15;
                t_en  = run && ((((m_cfg[i] >> 10) & 1) == 0) || m_gate) &&
                        ((((m_cfg[i] >> 8) & 1) == 1) || evt_strobe[t_sel]);
                t_inc = (((m_cfg[i] >> 9) & 1) == 1) ? longint'(wgt(m_ratio)) : 1;
                t_cnt[i] = m_cnt[i];
                t_ovf[i] = m_ovf[i];
                if (t_clr) begin
                    t_cnt[i] = 0; t_ovf[i] = 0;
                end else if (!m_ovf[i] && t_en) begin
                    t_sum = m_cnt[i] + t_inc;
                    if (t_sum > MAXC) begin
                        t_cnt[i] = MAXC; t_ovf[i] = 1;
                    end else begin
                        t_cnt[i] = t_sum;
                    end
                end
            end
            if (!run) m_gate = 0;
            else if (pc_valid && longint'(fetch_pc) == m_start) m_gate = 1;
            else if (pc_valid && longint'(fetch_pc) == m_end) m_gate = 0;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_cfg[0] = int'(wr_data & 32'h7FF);
                    3'd1: m_cfg[1] = int'(wr_data & 32'h7FF);
                    3'd2: m_start = longint'(wr_data);
                    3'd3: m_end   = longint'(wr_data);
                    3'd4: m_ratio = int'(wr_data & 32'h7);
                    default: ;
                endcase
            end
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = t_cnt[i]; m_ovf[i] = t_ovf[i]; m_hi[i] = t_hi[i];
            end
        end
    end

    function automatic logic [31:0] exp_rd(logic [1:0] a);
        int ch;
        ch = int'(a[1]);
        if (a[0]) return (m_ovf[ch] ? 32'h8000_0000 : 32'h0) | 32'(m_hi[ch]);
        return 32'(m_cnt[ch] & 255);
    endfunction

    // Per-cycle comparison of the read port against the model
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            checks++;
            if (rd_data !== exp_rd(rd_addr)) begin
                errors++;
                $display("FAIL R9 per-cycle readout addr %0d: got %0h expected %0h",
                         rd_addr, rd_data, exp_rd(rd_addr));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(string tag, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic next();
        @(posedge clk);
        #2;
        clear = '0; wr_en = 1'b0; rd_en = 1'b0;
        if (rnd_evt) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            evt_strobe = lfsr;
        end
    endtask

    task automatic cycles(int n);
        repeat (n) next();
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        next();
    endtask

    task automatic peek(logic [1:0] a, output longint v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        #1;
        v = longint'(rd_data);
    endtask

    task automatic pcs(logic [31:0] v, int n);
        fetch_pc = v;
        cycles(n);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired (all requirements)");
            finish_run();
        end
    end

    initial begin
        longint v, lo, hi, ref0;
        rst_n = 0; run = 0; clear = '0; evt_strobe = '0; pc_valid = 1;
        fetch_pc = 32'h50; wr_en = 0; wr_addr = '0; wr_data = '0;
        rd_en = 0; rd_addr = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        next();

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), v);
            chk("R1 reset value", v, 0);
            next();
        end

        // R2/R3: ch0 counts event line 3, ch1 counts elapsed cycles
        wr(3'd0, 32'h003);
        wr(3'd1, 32'h100);
        rnd_evt = 1;
        run = 1;
        cycles(50);
        run = 0;
        peek(2'd2, v);
        chk("R2 elapsed count over 50 running cycles", v, 50);
        ref0 = m_cnt[0];
        peek(2'd0, v);
        chk("R3 ch0 event count independent of ch1", v, ref0 & 255);
        next();
        cycles(10);
        peek(2'd2, v);
        chk("R2 no counting while run low", v, 50);
        peek(2'd0, v);
        chk("R2 ch0 unchanged while run low", v, ref0 & 255);
        next();
        rnd_evt = 0;
        evt_strobe = '0;

        // R4: ratio weights for every code
        wr(3'd0, 32'h300);
        for (int c = 0; c < 8; c++) begin
            wr(3'd4, 32'(c));
            clear = 2'b01;
            next();
            run = 1;
            cycles(5);
            run = 0;
            peek(2'd0, v);
            chk($sformatf("R4 ratio code %0d weight", c), v, 5 * wgt(c));
            next();
        end
        wr(3'd0, 32'h100);
        run = 1;
        cycles(7);
        run = 0;
        peek(2'd0, v);
        chk("R4 cpu-clock mode adds one", v, 7);
        next();

        // R8: clear pulse and configuration write both zero the count
        wr(3'd1, 32'h100);
        run = 1;
        cycles(10);
        clear = 2'b10;
        next();
        peek(2'd2, v);
        chk("R8 clear pulse zeroes count while counting", v, 0);
        next();
        cycles(3);
        wr(3'd1, 32'h100);
        peek(2'd2, v);
        chk("R8 config write zeroes count", v, 0);
        next();
        run = 0;
        next();

        // R5: window opens after start, end cycle counted
        wr(3'd2, 32'h100);
        wr(3'd3, 32'h200);
        wr(3'd1, 32'h500);
        run = 1;
        pcs(32'h50, 3);
        pcs(32'h100, 1);
        pcs(32'h50, 4);
        pcs(32'h200, 1);
        pcs(32'h50, 3);
        run = 0;
        peek(2'd2, v);
        chk("R5 window count start..end", v, 5);
        next();

        // R5: start wins when start and end match together
        wr(3'd3, 32'h100);
        wr(3'd1, 32'h500);
        run = 1;
        pcs(32'h100, 1);
        pcs(32'h50, 3);
        run = 0;
        next();
        run = 1;
        pcs(32'h50, 4);
        run = 0;
        peek(2'd2, v);
        chk("R5 start priority and run-low close", v, 3);
        next();

        // R6: rewritten pair serves both channels
        wr(3'd2, 32'h300);
        wr(3'd3, 32'h400);
        wr(3'd0, 32'h500);
        wr(3'd1, 32'h500);
        run = 1;
        pcs(32'h100, 1);
        pcs(32'h50, 2);
        pcs(32'h300, 1);
        pcs(32'h50, 3);
        pcs(32'h400, 1);
        pcs(32'h50, 2);
        run = 0;
        peek(2'd0, v);
        chk("R6 ch0 uses new shared pair", v, 4);
        peek(2'd2, v);
        chk("R6 ch1 uses new shared pair", v, 4);
        next();

        // R9: coherent split read across a low-part rollover
        wr(3'd1, 32'h100);
        run = 1;
        cycles(255);
        peek(2'd2, lo);
        chk("R9 low part before rollover", lo, 255);
        next();
        peek(2'd3, hi);
        chk("R9 high part captured with low read", (hi & 63) * 256 + lo, 255);
        next();
        run = 0;
        next();

        // R7: overflow saturates and sticks
        wr(3'd0, 32'h300);
        wr(3'd4, 32'h5);
        run = 1;
        cycles(700);
        run = 0;
        peek(2'd0, v);
        chk("R7 saturated low part", v, 255);
        next();
        peek(2'd1, v);
        chk("R7 overflow flag and saturated high part", v, 32'h8000_003F);
        next();
        run = 1;
        cycles(5);
        run = 0;
        peek(2'd0, v);
        chk("R7 count frozen after overflow", v, 255);
        next();
        clear = 2'b01;
        next();
        peek(2'd1, v);
        chk("R8 clear drops overflow flag", v >> 31, 0);
        peek(2'd0, v);
        chk("R8 clear zeroes saturated count", v, 0);
        next();

        finish_run();
    end

endmodule